// File: doc/BRIEF.md
# VCO Band Select Sequencer

This block runs the automatic coarse band choice for a synthesizer VCO that covers its tuning range with eight overlapping bands. A selection window opens by itself when reset is released, and again whenever the N-counter register is written (`trigger_i`). While the window is open, the block holds the VCO tuning node on an internal reference instead of the loop filter (`tune_hold_o`). It then narrows the 3-bit band index with a binary search driven by the up/down result of the frequency detector.

The window is timed by a band-select clock. This clock is the R-counter output pulse stream divided by 1, 2, 4 or 8, chosen by a 2-bit field. The window lasts five ticks of that clock. The first three ticks each resolve one band bit, most significant first, and the last two are settling time. When the fifth tick lands, the hold is released, a one-cycle completion strobe is given, and normal loop action resumes with the chosen band. A new trigger inside a window restarts the search from its first tick.

Top module: `vco_band_sel`

## Requirements
- R1: While `rst_ni` is low, `busy_o`, `tune_hold_o` and `done_o` are 0 and `band_o` is 3'b000.
- R2: On the first clock edge after reset is released, a selection window opens without any trigger: `busy_o` is 1 and `band_o` is 3'b100 after that edge.
- R3: A `trigger_i` high at a clock edge opens a window: after that edge `busy_o` is 1 and `band_o` is 3'b100 (trial value with only the MSB set).
- R4: The band-select tick is every 2^k-th `rcnt_pulse_i` seen inside the window, where k is the value of `div_sel_i` (0 gives 1, 1 gives 2, 2 gives 4, 3 gives 8). Counting starts fresh at each window start, and a pulse coinciding with a trigger is not counted.
- R5: A window lasts exactly five ticks. `busy_o` falls on the edge of the fifth tick.
- R6: On ticks 1, 2 and 3, band bits 2, 1 and 0 are resolved in that order. The bit under test becomes the value of `cmp_up_i` at that edge (1 means the VCO runs too low and the bit is kept), and the next lower bit is set as the new trial. With a monotonic comparator the final index equals the target band.
- R7: `band_o` changes on no edge other than a window start or one of the first three ticks; in particular it is held through the settling ticks and while idle.
- R8: `tune_hold_o` is high exactly while `busy_o` is high.
- R9: A trigger during a window restarts it: `band_o` returns to 3'b100 and five full ticks are needed again.
- R10: `done_o` is a one-cycle pulse, high in the cycle after the edge on which `busy_o` falls.
- R11: `div_sel_i` is captured when a window opens; changing it during the window has no effect on that window's length.
- R12: `rcnt_pulse_i` has no effect while no window is open: `busy_o` stays 0 and `band_o` keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low (power-on) |
| trigger_i | input | 1 | One-cycle strobe on an N-counter register write |
| rcnt_pulse_i | input | 1 | One-cycle R-counter output pulse |
| div_sel_i | input | 2 | Band clock divide select: ratio 2^value |
| cmp_up_i | input | 1 | Frequency comparison: 1 means select a higher band |
| busy_o | output | 1 | Selection window open |
| tune_hold_o | output | 1 | Tuning node tied to internal reference |
| band_o | output | 3 | VCO band index |
| done_o | output | 1 | One-cycle strobe when a window completes |

## Verification
The hardest situations to reach are those where events overlap the window edges. These include a restart trigger landing partway through the prescaled count, a trigger arriving in the same cycle as an R-counter pulse, and a divide select that changes inside an open window. The bench places these directly by counting the pulses it delivers and acting at chosen counts. A comparator model tied to `band_o` stands in for the frequency detector. Random windows then mix all divide ratios, all eight targets and irregular pulse spacing, and each intermediate band value is checked after every pulse.

// File: rtl/vbs_pkg.sv
package vbs_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } vbs_state_e;
endpackage

// File: rtl/vbs_prescaler.sv
module vbs_prescaler #(
  parameter int SEL_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             en_i,
  input  logic             pulse_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  localparam int CNT_W = (1 << SEL_W) - 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] mask;
  logic             hit;

  // ratio 2^sel: low sel bits of counter all ones marks the last pulse
  for (genvar b = 0; b < CNT_W; b++) begin : g_mask
    assign mask[b] = (sel_i > SEL_W'(b));
  end

  assign hit    = ((cnt_q & mask) == mask);
  assign tick_o = en_i & pulse_i & hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (clear_i) begin
      cnt_q <= '0;
    end else if (en_i && pulse_i) begin
      cnt_q <= hit ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/vbs_seq.sv
module vbs_seq #(
  parameter int STEPS  = 5,
  parameter int STEP_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              tick_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [STEP_W-1:0] step_o
);
  import vbs_pkg::*;

  vbs_state_e        state_q;
  logic [STEP_W-1:0] step_q;
  logic              done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      step_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        state_q <= ST_RUN;
        step_q  <= '0;
      end else if (state_q == ST_RUN && tick_i) begin
        if (step_q == STEP_W'(STEPS - 1)) begin
          state_q <= ST_IDLE;
          step_q  <= '0;
          done_q  <= 1'b1;
        end else begin
          step_q <= step_q + 1'b1;
        end
      end
    end
  end

  assign busy_o = (state_q == ST_RUN);
  assign done_o = done_q;
  assign step_o = step_q;
endmodule

// File: rtl/vbs_sar.sv
module vbs_sar #(
  parameter int BAND_W = 3,
  parameter int STEP_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              tick_i,
  input  logic [STEP_W-1:0] step_i,
  input  logic              cmp_up_i,
  output logic [BAND_W-1:0] band_o
);
  localparam logic [BAND_W-1:0] MSB = BAND_W'(1) << (BAND_W - 1);

  logic [BAND_W-1:0] band_q;
  logic [BAND_W-1:0] cur;
  logic [BAND_W-1:0] nxt;
  logic              resolving;

  assign resolving = (step_i < STEP_W'(BAND_W));
  assign cur       = MSB >> step_i;

  // resolve bit under test, then place trial on the next lower bit
  always_comb begin
    nxt = (band_q & ~cur) | (cur >> 1);
    if (cmp_up_i) nxt = nxt | cur;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      band_q <= '0;
    end else if (start_i) begin
      band_q <= MSB;
    end else if (tick_i && resolving) begin
      band_q <= nxt;
    end
  end

  assign band_o = band_q;
endmodule

// File: rtl/vco_band_sel.sv
module vco_band_sel #(
  parameter int BAND_W = 3,
  parameter int SEL_W  = 2,
  parameter int SETTLE = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              trigger_i,
  input  logic              rcnt_pulse_i,
  input  logic [SEL_W-1:0]  div_sel_i,
  input  logic              cmp_up_i,
  output logic              busy_o,
  output logic              tune_hold_o,
  output logic [BAND_W-1:0] band_o,
  output logic              done_o
);
  localparam int STEPS  = BAND_W + SETTLE;
  localparam int STEP_W = $clog2(STEPS);

  logic              por_pend_q;
  logic              start;
  logic              busy;
  logic              tick;
  logic [SEL_W-1:0]  sel_q;
  logic [STEP_W-1:0] step;

  assign start = trigger_i | por_pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      por_pend_q <= 1'b1;
      sel_q      <= '0;
    end else begin
      por_pend_q <= 1'b0;
      if (start) sel_q <= div_sel_i;
    end
  end

  vbs_prescaler #(.SEL_W(SEL_W)) i_presc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (start),
    .en_i    (busy & ~start),
    .pulse_i (rcnt_pulse_i),
    .sel_i   (sel_q),
    .tick_o  (tick)
  );

  vbs_seq #(.STEPS(STEPS), .STEP_W(STEP_W)) i_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .tick_i  (tick),
    .busy_o  (busy),
    .done_o  (done_o),
    .step_o  (step)
  );

  vbs_sar #(.BAND_W(BAND_W), .STEP_W(STEP_W)) i_sar (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start),
    .tick_i   (tick),
    .step_i   (step),
    .cmp_up_i (cmp_up_i),
    .band_o   (band_o)
  );

  assign busy_o      = busy;
  assign tune_hold_o = busy;
endmodule

// File: rtl/vbs_chk.sv
module vbs_chk #(
  parameter int BAND_W = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              trigger_i,
  input logic              rcnt_pulse_i,
  input logic              busy_o,
  input logic              tune_hold_o,
  input logic [BAND_W-1:0] band_o,
  input logic              done_o
);
  localparam logic [BAND_W-1:0] MSB = BAND_W'(1) << (BAND_W - 1);

  // R3
  trigger_opens_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trigger_i |=> busy_o && band_o == MSB);

  // R4
  no_pulse_no_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !rcnt_pulse_i && !trigger_i |=> busy_o && $stable(band_o));

  // R6
  one_bit_per_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !trigger_i |=> $countones(band_o ^ $past(band_o)) <= 2);

  // R7
  idle_band_held_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> $stable(band_o));

  // R8
  hold_tracks_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tune_hold_o == busy_o);

  // R10
  done_after_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);

  // R10
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R12
  idle_pulse_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && !trigger_i && !done_o && rcnt_pulse_i |=> !busy_o);
endmodule

bind vco_band_sel vbs_chk #(.BAND_W(BAND_W)) i_vbs_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .trigger_i    (trigger_i),
  .rcnt_pulse_i (rcnt_pulse_i),
  .busy_o       (busy_o),
  .tune_hold_o  (tune_hold_o),
  .band_o       (band_o),
  .done_o       (done_o)
);

// File: tb/test_vco_band_sel.sv
module test_vco_band_sel;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       trigger_i = 1'b0;
  logic       rcnt_pulse_i = 1'b0;
  logic [1:0] div_sel_i = 2'd0;
  logic       cmp_up_i;
  logic       busy_o, tune_hold_o, done_o;
  logic [2:0] band_o;
  int         target = 0;
  int         checks = 0;
  int         failures = 0;
  bit         finished = 1'b0;

  always #5 clk_i = ~clk_i;

  // monotonic frequency detector model
  assign cmp_up_i = (int'(band_o) <= target);

  vco_band_sel i_vco_band_sel (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .trigger_i    (trigger_i),
    .rcnt_pulse_i (rcnt_pulse_i),
    .div_sel_i    (div_sel_i),
    .cmp_up_i     (cmp_up_i),
    .busy_o       (busy_o),
    .tune_hold_o  (tune_hold_o),
    .band_o       (band_o),
    .done_o       (done_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  task automatic step_clk();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  // band after t ticks of a binary search toward tgt
  function automatic int exp_band(input int tgt, input int t);
    case (t)
      0:       return 4;
      1:       return (tgt & 4) | 2;
      2:       return (tgt & 6) | 1;
      default: return tgt;
    endcase
  endfunction

  task automatic start_sel(input int div, input int tgt, input string req);
    div_sel_i = 2'(div);
    target    = tgt;
    trigger_i = 1'b1;
    step_clk();
    trigger_i = 1'b0;
    chk(busy_o == 1'b1, req, "busy after trigger", int'(busy_o), 1);
    chk(int'(band_o) == 4, req, "trial band after trigger", int'(band_o), 4);
  endtask

  // deliver pulses first..last of a window with ratio r
  task automatic run_pulses(input int r, input int tgt, input int first,
                            input int last, input int gap);
    for (int p = first; p <= last; p++) begin
      int t = p / r;
      rcnt_pulse_i = 1'b1;
      step_clk();
      rcnt_pulse_i = 1'b0;
      if (p < 5 * r) begin
        chk(busy_o == 1'b1, "R5", "busy inside window", int'(busy_o), 1);
        chk(tune_hold_o == 1'b1, "R8", "hold inside window", int'(tune_hold_o), 1);
        chk(int'(band_o) == exp_band(tgt, t), "R6", "intermediate band",
            int'(band_o), exp_band(tgt, t));
      end else begin
        chk(busy_o == 1'b0, "R5", "busy after fifth tick", int'(busy_o), 0);
        chk(tune_hold_o == 1'b0, "R8", "hold released", int'(tune_hold_o), 0);
        chk(done_o == 1'b1, "R10", "done strobe", int'(done_o), 1);
        chk(int'(band_o) == tgt, "R6", "final band", int'(band_o), tgt);
        step_clk();
        chk(done_o == 1'b0, "R10", "done one cycle", int'(done_o), 0);
      end
      for (int g = 0; g < gap; g++) step_clk();
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    checks++;
    failures++;
    $display("FAIL watchdog: act=%0d exp=%0d", 1, 0);
    summary();
  end

  initial begin
    void'($urandom(32'd4918));
    target = 5;
    repeat (3) @(negedge clk_i);
    // R1
    chk(busy_o == 1'b0, "R1", "busy in reset", int'(busy_o), 0);
    chk(tune_hold_o == 1'b0, "R1", "hold in reset", int'(tune_hold_o), 0);
    chk(done_o == 1'b0, "R1", "done in reset", int'(done_o), 0);
    chk(band_o == 3'd0, "R1", "band in reset", int'(band_o), 0);

    // R2: power-up window, ratio 1
    rst_ni = 1'b1;
    step_clk();
    chk(busy_o == 1'b1, "R2", "busy after reset release", int'(busy_o), 1);
    chk(int'(band_o) == 4, "R2", "trial band at power-up", int'(band_o), 4);
    run_pulses(1, 5, 1, 5, 0);

    // R12: pulses while idle
    for (int i = 0; i < 6; i++) begin
      rcnt_pulse_i = 1'b1;
      step_clk();
      rcnt_pulse_i = 1'b0;
      chk(busy_o == 1'b0, "R12", "idle pulse opens nothing", int'(busy_o), 0);
      chk(int'(band_o) == 5, "R12", "idle band kept", int'(band_o), 5);
    end

    // R6 extremes at every ratio (R3, R4)
    for (int d = 0; d < 4; d++) begin
      start_sel(d, 0, "R3");
      run_pulses(1 << d, 0, 1, 5 * (1 << d), 1);
      start_sel(d, 7, "R3");
      run_pulses(1 << d, 7, 1, 5 * (1 << d), 0);
    end

    // R9: restart partway, then full window again
    start_sel(2, 6, "R3");
    run_pulses(4, 6, 1, 9, 0);
    start_sel(2, 1, "R9");
    run_pulses(4, 1, 1, 20, 0);

    // R4: pulse coinciding with trigger is not counted
    div_sel_i = 2'd1;
    target = 3;
    trigger_i = 1'b1;
    rcnt_pulse_i = 1'b1;
    step_clk();
    trigger_i = 1'b0;
    rcnt_pulse_i = 1'b0;
    chk(int'(band_o) == 4, "R4", "coinciding pulse ignored", int'(band_o), 4);
    run_pulses(2, 3, 1, 10, 0);

    // R11: div change inside window
    start_sel(1, 2, "R3");
    run_pulses(2, 2, 1, 1, 0);
    div_sel_i = 2'd3;
    run_pulses(2, 2, 2, 10, 1);

    // random windows
    for (int n = 0; n < 40; n++) begin
      int d = int'($urandom_range(3, 0));
      int tg = int'($urandom_range(7, 0));
      int gp = int'($urandom_range(2, 0));
      start_sel(d, tg, "R3");
      div_sel_i = 2'($urandom_range(3, 0));
      run_pulses(1 << d, tg, 1, 5 * (1 << d), gp);
    end

    summary();
  end
endmodule